// File: doc/BRIEF.md
# Dual-Issue Reservation Station with Serialized Memory Issue

This block holds renamed instructions for a two-wide out-of-order core until their source operands are available, then sends them to execution. It has eight slots. Each cycle it can accept up to two instructions from dispatch, and a priority selector places them in the lowest-numbered free slots. It watches two result buses for destination tags. When a broadcast tag matches a waiting source, that source is marked ready.

A second priority selector picks up to two ready entries per cycle, lowest slot index first. Ordering is by slot, not by age, so an instruction whose operands are ready can pass an older one that is still waiting. The memory path behind this block is blocking. For that reason no more than one load or store is sent per cycle, and loads are held back while the memory system reports that it is busy. Stores are not held by that signal. A flush empties the station.

Dispatch uses the `full` output to stall its pair. Issued packets appear combinationally from the current contents of the station and the current broadcasts. The execution side accepts them unconditionally.

Top module: `dual_issue_station`

## Requirements
- R1: After reset the station is empty: `full` is 0 and `iss_valid` is 0.
- R2: `full` is 1 exactly when fewer than two of the eight slots are free. Six held entries give `full`=0 and seven give `full`=1.
- R3: While `full` is 1, instructions presented on dispatch are dropped and never issue.
- R4: A tag on either result bus (`wb_valid[k]` with `wb_tag` bits `[k*TW +: TW]`) readies every matching held source in that same cycle. A waiting entry can therefore issue in the broadcast cycle, and it stays ready afterwards.
- R5: An entry dispatched with both sources ready can issue in the cycle after dispatch, and not in the dispatch cycle.
- R6: Issue lane 0 carries the eligible entry in the lowest slot, and lane 1 carries the next one. Lane 1 is never valid without lane 0. Dispatch lane 0 fills the lowest free slot.
- R7: A ready non-memory instruction issues ahead of an earlier-dispatched instruction that is still waiting.
- R8: At most one memory operation issues per cycle. Kind encoding is 2'b00 and 2'b11 for non-memory, 2'b01 for load and 2'b10 for store. When lane 0 carries a memory operation, lane 1 may still carry a ready non-memory instruction.
- R9: While `mem_busy` is 1 no load issues, but a ready store may.
- R10: `flush` suppresses issue in its cycle, drops that cycle's dispatch, and leaves every slot empty afterwards.
- R11: A source tag that is broadcast in the same cycle as its instruction is dispatched is recorded as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the station |
| disp_valid | input | 2 | Dispatch lane valid bits |
| disp_kind | input | 4 | Per-lane instruction kind, 2 bits each |
| disp_dst | input | 2*TW | Per-lane destination tag |
| disp_src_a | input | 2*TW | Per-lane first source tag |
| disp_rdy_a | input | 2 | Per-lane first source ready at dispatch |
| disp_src_b | input | 2*TW | Per-lane second source tag |
| disp_rdy_b | input | 2 | Per-lane second source ready at dispatch |
| disp_pay | input | 2*PW | Per-lane opaque instruction payload |
| wb_valid | input | 2 | Result bus valid bits |
| wb_tag | input | 2*TW | Result bus tags |
| mem_busy | input | 1 | Memory system has a load in flight |
| full | output | 1 | Fewer than two free slots |
| iss_valid | output | 2 | Issue lane valid bits |
| iss_kind | output | 4 | Issued kinds |
| iss_dst | output | 2*TW | Issued destination tags |
| iss_pay | output | 2*PW | Issued payloads |

## Verification
The effects of a corrupt slot valid bit or ready bit appear at the ports quickly. A lost entry never reaches `iss_valid`. A stuck ready bit makes an entry issue in the cycle after dispatch, before its broadcast. A valid bit that is wrongly left set shows up as a duplicate payload in the next cycle. Errors in the selectors appear in the same cycle as swapped or paired payloads on the issue lanes. A wrong occupancy count shows as `full` at the wrong fill level, or as a dropped pair that later issues.

// File: rtl/dual_issue_station.sv
module dual_issue_station #(
  parameter int DEPTH = 8,
  parameter int TW = 6,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [1:0]      disp_valid,
  input  logic [3:0]      disp_kind,
  input  logic [2*TW-1:0] disp_dst,
  input  logic [2*TW-1:0] disp_src_a,
  input  logic [1:0]      disp_rdy_a,
  input  logic [2*TW-1:0] disp_src_b,
  input  logic [1:0]      disp_rdy_b,
  input  logic [2*PW-1:0] disp_pay,
  input  logic [1:0]      wb_valid,
  input  logic [2*TW-1:0] wb_tag,
  input  logic            mem_busy,
  output logic            full,
  output logic [1:0]      iss_valid,
  output logic [3:0]      iss_kind,
  output logic [2*TW-1:0] iss_dst,
  output logic [2*PW-1:0] iss_pay
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [1:0] K_LD = 2'b01;
  localparam logic [1:0] K_ST = 2'b10;

  logic [DEPTH-1:0] valid_q;
  logic [1:0]       kind_q  [DEPTH];
  logic [TW-1:0]    dst_q   [DEPTH];
  logic [TW-1:0]    src_a_q [DEPTH];
  logic [TW-1:0]    src_b_q [DEPTH];
  logic [DEPTH-1:0] r_a_q, r_b_q;
  logic [PW-1:0]    pay_q   [DEPTH];

  function automatic logic hit(input logic [TW-1:0] t, input logic [1:0] v,
                               input logic [2*TW-1:0] tags);
    return (v[0] && tags[TW-1:0] == t) || (v[1] && tags[2*TW-1:TW] == t);
  endfunction

  function automatic logic is_mem(input logic [1:0] k);
    return k == K_LD || k == K_ST;
  endfunction

  logic [DEPTH-1:0] rdy_a_now, rdy_b_now, elig0, elig1, take, wr0, wr1;
  logic             sel0_ok, sel1_ok, fr0_ok, fr1_ok, accept;
  logic [IW-1:0]    sel0, sel1, fr0, fr1, slot1;
  int               n_free;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rdy_a_now[i] = r_a_q[i] | hit(src_a_q[i], wb_valid, wb_tag);
      rdy_b_now[i] = r_b_q[i] | hit(src_b_q[i], wb_valid, wb_tag);
      elig0[i] = valid_q[i] && rdy_a_now[i] && rdy_b_now[i] &&
                 !(kind_q[i] == K_LD && mem_busy) && !flush;
    end
  end

  always_comb begin
    sel0_ok = 1'b0;
    sel0 = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (elig0[i]) begin
        sel0_ok = 1'b1;
        sel0 = IW'(i);
      end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      elig1[i] = elig0[i] && !(sel0_ok && (sel0 == IW'(i) ||
                 (is_mem(kind_q[sel0]) && is_mem(kind_q[i]))));
    sel1_ok = 1'b0;
    sel1 = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (elig1[i]) begin
        sel1_ok = 1'b1;
        sel1 = IW'(i);
      end
  end

  always_comb begin
    n_free = 0;
    fr0_ok = 1'b0;
    fr0 = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!valid_q[i]) begin
        n_free = n_free + 1;
        fr0_ok = 1'b1;
        fr0 = IW'(i);
      end
    fr1_ok = 1'b0;
    fr1 = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!valid_q[i] && !(fr0_ok && fr0 == IW'(i))) begin
        fr1_ok = 1'b1;
        fr1 = IW'(i);
      end
  end

  assign full   = n_free < 2;
  assign accept = !full && !flush;
  assign slot1  = disp_valid[0] ? fr1 : fr0;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      take[i] = (sel0_ok && sel0 == IW'(i)) || (sel1_ok && sel1 == IW'(i));
      wr0[i]  = accept && disp_valid[0] && fr0_ok && fr0 == IW'(i);
      wr1[i]  = accept && disp_valid[1] && slot1 == IW'(i) &&
                (disp_valid[0] ? fr1_ok : fr0_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     valid_q <= '0;
    else if (flush) valid_q <= '0;
    else            valid_q <= (valid_q & ~take) | wr0 | wr1;

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++) begin
      if (wr0[i]) begin
        kind_q[i]  <= disp_kind[1:0];
        dst_q[i]   <= disp_dst[TW-1:0];
        src_a_q[i] <= disp_src_a[TW-1:0];
        src_b_q[i] <= disp_src_b[TW-1:0];
        r_a_q[i]   <= disp_rdy_a[0] | hit(disp_src_a[TW-1:0], wb_valid, wb_tag);
        r_b_q[i]   <= disp_rdy_b[0] | hit(disp_src_b[TW-1:0], wb_valid, wb_tag);
        pay_q[i]   <= disp_pay[PW-1:0];
      end else if (wr1[i]) begin
        kind_q[i]  <= disp_kind[3:2];
        dst_q[i]   <= disp_dst[2*TW-1:TW];
        src_a_q[i] <= disp_src_a[2*TW-1:TW];
        src_b_q[i] <= disp_src_b[2*TW-1:TW];
        r_a_q[i]   <= disp_rdy_a[1] | hit(disp_src_a[2*TW-1:TW], wb_valid, wb_tag);
        r_b_q[i]   <= disp_rdy_b[1] | hit(disp_src_b[2*TW-1:TW], wb_valid, wb_tag);
        pay_q[i]   <= disp_pay[2*PW-1:PW];
      end else begin
        r_a_q[i]   <= rdy_a_now[i];
        r_b_q[i]   <= rdy_b_now[i];
      end
    end

  assign iss_valid = {sel1_ok, sel0_ok};
  assign iss_kind  = {kind_q[sel1], kind_q[sel0]};
  assign iss_dst   = {dst_q[sel1], dst_q[sel0]};
  assign iss_pay   = {pay_q[sel1], pay_q[sel0]};
endmodule

// File: rtl/station_chk.sv
module station_chk #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             mem_busy,
  input logic             full,
  input logic [1:0]       iss_valid,
  input logic [3:0]       iss_kind,
  input logic [DEPTH-1:0] valid_q
);
  logic mem0, mem1;
  assign mem0 = iss_kind[1:0] == 2'b01 || iss_kind[1:0] == 2'b10;
  assign mem1 = iss_kind[3:2] == 2'b01 || iss_kind[3:2] == 2'b10;

  // R8
  one_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid == 2'b11 && mem0 && mem1));

  // R9
  load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !((iss_valid[0] && iss_kind[1:0] == 2'b01) ||
                   (iss_valid[1] && iss_kind[3:2] == 2'b01)));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $countones(valid_q) <= $past($countones(valid_q)));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> iss_valid == 2'b00);

  // R6
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> iss_valid[0]);
endmodule

bind dual_issue_station station_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .mem_busy(mem_busy), .full(full),
  .iss_valid(iss_valid), .iss_kind(iss_kind), .valid_q(valid_q)
);

// File: tb/tb_dual_issue_station.sv
`timescale 1ns/1ps
module tb_dual_issue_station;
  localparam logic [1:0] ALU = 2'b00, LD = 2'b01, ST = 2'b10;

  logic        clk = 0, rst_n = 0, flush = 0, mem_busy = 0;
  logic [1:0]  disp_valid, disp_rdy_a, disp_rdy_b, wb_valid;
  logic [3:0]  disp_kind;
  logic [11:0] disp_dst, disp_src_a, disp_src_b, wb_tag;
  logic [15:0] disp_pay;
  logic        full;
  logic [1:0]  iss_valid;
  logic [3:0]  iss_kind;
  logic [11:0] iss_dst;
  logic [15:0] iss_pay;
  int tests = 0, fails = 0;

  dual_issue_station dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp_kind(disp_kind), .disp_dst(disp_dst), .disp_src_a(disp_src_a),
    .disp_rdy_a(disp_rdy_a), .disp_src_b(disp_src_b), .disp_rdy_b(disp_rdy_b),
    .disp_pay(disp_pay), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .mem_busy(mem_busy), .full(full), .iss_valid(iss_valid),
    .iss_kind(iss_kind), .iss_dst(iss_dst), .iss_pay(iss_pay)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 20000);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic clr();
    disp_valid = 0; disp_kind = 0; disp_dst = 0; disp_src_a = 0; disp_src_b = 0;
    disp_rdy_a = 0; disp_rdy_b = 0; disp_pay = 0; wb_valid = 0; wb_tag = 0; flush = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic d(input int ln, input logic [1:0] k, input logic [5:0] sa, input logic ra,
                   input logic [5:0] sb, input logic rb, input logic [7:0] p);
    disp_valid[ln] = 1'b1;
    disp_kind[ln*2 +: 2] = k;
    disp_dst[ln*6 +: 6] = 6'(p);
    disp_src_a[ln*6 +: 6] = sa;
    disp_rdy_a[ln] = ra;
    disp_src_b[ln*6 +: 6] = sb;
    disp_rdy_b[ln] = rb;
    disp_pay[ln*8 +: 8] = p;
  endtask

  task automatic wb(input int b, input logic [5:0] t);
    wb_valid[b] = 1'b1;
    wb_tag[b*6 +: 6] = t;
  endtask

  task automatic see(input string req, input logic [1:0] v, input logic [7:0] p0, input logic [7:0] p1);
    logic ok;
    #1;
    ok = (iss_valid == v) && (!v[0] || iss_pay[7:0] == p0) && (!v[1] || iss_pay[15:8] == p1);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: issue v=%b pay=%h/%h, expected v=%b pay=%h/%h",
               req, iss_valid, iss_pay[7:0], iss_pay[15:8], v, p0, p1);
    end
  endtask

  task automatic see_full(input string req, input logic e);
    #1;
    tests++;
    if (full !== e) begin
      fails++;
      $display("FAIL %s: full=%b expected=%b", req, full, e);
    end
  endtask

  task automatic empty_out();
    tick(); flush = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    see_full("R1", 1'b0);
    see("R1", 2'b00, 0, 0);
  endtask

  task automatic t_capacity();
    tick(); d(0, ALU, 5, 0, 5, 0, 8'h10); d(1, ALU, 5, 0, 5, 0, 8'h11); see_full("R2", 1'b0);
    tick(); d(0, ALU, 5, 0, 5, 0, 8'h12); d(1, ALU, 5, 0, 5, 0, 8'h13); see("R4", 2'b00, 0, 0);
    tick(); d(0, ALU, 5, 0, 5, 0, 8'h14); d(1, ALU, 5, 0, 5, 0, 8'h15);
    tick(); d(0, ALU, 5, 0, 5, 0, 8'h16); see_full("R2", 1'b0);
    tick(); d(0, ALU, 1, 1, 1, 1, 8'h77); d(1, ALU, 1, 1, 1, 1, 8'h78); see_full("R2", 1'b1);
    see("R3", 2'b00, 0, 0);
    tick(); wb(0, 5); see("R4", 2'b11, 8'h10, 8'h11);
    tick(); see("R6", 2'b11, 8'h12, 8'h13);
    tick(); see("R6", 2'b11, 8'h14, 8'h15);
    tick(); see("R6", 2'b01, 8'h16, 0);
    tick(); see("R3", 2'b00, 0, 0);
    see_full("R3", 1'b0);
  endtask

  task automatic t_bus1_wake();
    tick(); d(0, ALU, 1, 1, 9, 0, 8'h50);
    tick(); see("R4", 2'b00, 0, 0);
    tick(); wb(0, 3); wb(1, 9); see("R4", 2'b01, 8'h50, 0);
    tick(); see("R4", 2'b00, 0, 0);
  endtask

  task automatic t_ready_dispatch();
    tick(); d(1, ALU, 0, 1, 0, 1, 8'h60); see("R5", 2'b00, 0, 0);
    tick(); see("R5", 2'b01, 8'h60, 0);
  endtask

  task automatic t_out_of_order();
    tick(); d(0, ALU, 20, 0, 1, 1, 8'h70); d(1, ALU, 1, 1, 1, 1, 8'h71);
    tick(); see("R7", 2'b01, 8'h71, 0);
    tick(); see("R7", 2'b00, 0, 0);
    tick(); wb(0, 20); see("R7", 2'b01, 8'h70, 0);
  endtask

  task automatic t_one_mem();
    tick(); d(0, LD, 7, 0, 0, 1, 8'h80); d(1, ST, 7, 0, 0, 1, 8'h81);
    tick(); d(0, ALU, 7, 0, 7, 0, 8'h82); see("R8", 2'b00, 0, 0);
    tick(); wb(1, 7); see("R8", 2'b11, 8'h80, 8'h82);
    tick(); see("R8", 2'b01, 8'h81, 0);
    tick(); see("R8", 2'b00, 0, 0);
  endtask

  task automatic t_busy();
    tick(); mem_busy = 1'b1; d(0, LD, 0, 1, 0, 1, 8'h90); d(1, ST, 0, 1, 0, 1, 8'h91);
    tick(); see("R9", 2'b01, 8'h91, 0);
    tick(); see("R9", 2'b00, 0, 0);
    tick(); mem_busy = 1'b0; see("R9", 2'b01, 8'h90, 0);
    tick(); see("R9", 2'b00, 0, 0);
  endtask

  task automatic t_flush();
    tick(); d(0, ALU, 0, 1, 0, 1, 8'h40); d(1, ALU, 0, 1, 0, 1, 8'h41);
    tick(); flush = 1'b1; d(0, ALU, 0, 1, 0, 1, 8'h42); d(1, ALU, 0, 1, 0, 1, 8'h43);
    see("R10", 2'b00, 0, 0);
    tick(); see("R10", 2'b00, 0, 0);
    tick(); see("R10", 2'b00, 0, 0);
  endtask

  task automatic t_same_cycle_wake();
    tick(); d(0, ALU, 12, 0, 0, 1, 8'hA0); d(1, ALU, 0, 1, 12, 0, 8'hA1); wb(0, 12);
    see("R11", 2'b00, 0, 0);
    tick(); see("R11", 2'b11, 8'hA0, 8'hA1);
  endtask

  initial begin
    clr();
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_capacity();
    empty_out();
    t_bus1_wake();
    t_ready_dispatch();
    t_out_of_order();
    empty_out();
    t_one_mem();
    t_busy();
    t_flush();
    t_same_cycle_wake();
    tick();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule